// File: doc/BRIEF.md
# Freezable BCD Real-Time Clock Register Bank

This block is a calendar clock with eight byte-wide registers behind a parallel bus. The bus has active-low chip enable, output enable and write enable. Time is kept in packed BCD running counters. These counters are separate from the registers that software sees. A free-running enable at the crystal rate (32768 Hz by default) is divided inside the block into a one-second tick and a 512 Hz test square wave.

Two control bits decide how the visible registers relate to the counters. The write-hold bit stops the visible registers from following the counters and opens the time fields to bus writes. Clearing write-hold copies those fields into the counters and restarts counting from that point. The read-hold bit freezes the visible registers so that software can read a coherent time while the counters keep running; clearing it brings them up to date. An oscillator-stop bit halts the count. A frequency-test bit replaces the seconds LSB on reads with the test square wave. A power-fail input takes the block off the bus.

The address map is: 0 control (bit 7 write-hold, bit 6 read-hold, bits 5:0 century), 1 seconds (bit 7 oscillator-stop), 2 minutes, 3 hours (24-hour), 4 day of week (bit 6 frequency-test, bits 2:0 day 1..7), 5 date, 6 month, 7 year.

Top module: `bcd_rtc_regs`

## Requirements
- R1: The DQ outputs are enabled only when ce_n=0, oe_n=0 and we_n=1. With ce_n=1, or with oe_n=1 and we_n=1, or during a write (ce_n=0, we_n=0), dq_oe is 0.
- R2: While pwr_fail=1, dq_oe is 0 and bus writes have no effect on any register.
- R3: Writing 1 to control bit 7 sets write-hold, which then reads back as 1. While write-hold is set, writes to addresses 1..7 store the time fields and read back as written. While it is clear, writes to the time fields have no effect.
- R4: A control write with bit 7 = 0 while write-hold is set clears write-hold. It also loads the visible time fields into the counters and restarts the sub-second divider, so the first advance comes one full second later.
- R5: Writing 1 to control bit 6 freezes the visible time registers while the counters keep running. A later control write of 00h clears read-hold, and the visible registers then show the elapsed time.
- R6: Century (control bits 5:0) is written only by a control write that clears write-hold with bits 7 and 6 both 0. A control write that sets bit 7 or bit 6, or one that clears only read-hold, leaves the century unchanged.
- R7: Seconds and minutes roll over from 59 to 00, and hours from 23 to 00. Day of week counts 1..7 and wraps from 7 to 1 when the hour wraps.
- R8: Date rolls over to 01 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the BCD year is divisible by 4 (00 included) and 28 otherwise. All other months have 31. Month rolls from 12 to 01.
- R9: Year rolls from 99 to 00, and the century is not incremented by the rollover.
- R10: Seconds bit 7 = 1 stops the oscillator. No second is counted, and the bit reads back as 1. It can be written whether or not write-hold is set.
- R11: With day bit 6 = 1 and the oscillator running, a sustained read of address 1 shows bit 0 toggling as a 512 Hz square wave. With the oscillator stopped it shows the stored seconds LSB. Bit 6 can be written whether or not write-hold is set.
- R12: After reset, control reads 00h, seconds, minutes, hours and year read 00h, and day, date and month read 01h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle enable at the crystal rate |
| pwr_fail | input | 1 | Power-fail, deselects the bus |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 3 | Register address 0..7 |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data |
| dq_oe | output | 1 | Read data drive enable (0 = high impedance) |

## Verification
The calendar logic is tried with loaded times just before each kind of rollover: a 28-day February, a leap February, a 30-day month and the year wrap. These show whether each carry reaches the next field and whether the month length is chosen correctly. The hold bits are tried by letting a second pass while read-hold is set. Checking the frozen value first and the value after release shows a freeze apart from a stopped counter. Control writes with various century patterns show when the century is written. The test bit is tried as a sustained read with the oscillator running and then stopped. Every bus-mode combination is tried with and without power-fail, which separates output enable from write acceptance.

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs #(
  parameter int TICK_HZ = 32768,
  parameter int TEST_HZ = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       pwr_fail,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic [2:0] addr,
  input  logic [7:0] dq_in,
  output logic [7:0] dq_out,
  output logic       dq_oe
);
  localparam int PRE_W    = $clog2(TICK_HZ);
  localparam int TEST_BIT = $clog2(TICK_HZ / TEST_HZ) - 1;

  logic             w_bit, r_bit, osc_stop, ft_en;
  logic [5:0]       century;
  logic [PRE_W-1:0] pre;
  logic [7:0]       usr [1:7];
  logic [7:0]       cnt [1:7];
  logic [7:0]       nx  [1:7];

  logic wr, ctrl_wr, load, sec_tick, sec_lsb;
  assign wr       = !pwr_fail && !ce_n && !we_n;
  assign dq_oe    = !pwr_fail && !ce_n && !oe_n && we_n;
  assign ctrl_wr  = wr && (addr == 3'd0);
  assign load     = ctrl_wr && w_bit && !dq_in[7];
  assign sec_tick = osc_en && !osc_stop && (&pre);
  assign sec_lsb  = (ft_en && !osc_stop) ? pre[TEST_BIT] : usr[1][0];

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mo, input logic [7:0] yr);
    logic leap;
    leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                 : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
    case (mo)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_mask(input int i);
    case (i)
      1, 2:    return 8'h7F;
      3, 5:    return 8'h3F;
      4:       return 8'h07;
      6:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] reset_val(input int i);
    return (i >= 4 && i <= 6) ? 8'h01 : 8'h00;
  endfunction

  logic s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap;
  logic t_min, t_hr, t_day, t_mon, t_yr;
  assign s_wrap  = cnt[1] == 8'h59;
  assign m_wrap  = cnt[2] == 8'h59;
  assign h_wrap  = cnt[3] == 8'h23;
  assign d_wrap  = cnt[5] == month_len(cnt[6], cnt[7]);
  assign mo_wrap = cnt[6] == 8'h12;
  assign t_min   = sec_tick && s_wrap;
  assign t_hr    = t_min && m_wrap;
  assign t_day   = t_hr && h_wrap;
  assign t_mon   = t_day && d_wrap;
  assign t_yr    = t_mon && mo_wrap;

  always_comb begin
    nx[1] = sec_tick ? (s_wrap  ? 8'h00 : bcd_inc(cnt[1])) : cnt[1];
    nx[2] = t_min    ? (m_wrap  ? 8'h00 : bcd_inc(cnt[2])) : cnt[2];
    nx[3] = t_hr     ? (h_wrap  ? 8'h00 : bcd_inc(cnt[3])) : cnt[3];
    nx[4] = t_day    ? ((cnt[4] == 8'h07) ? 8'h01 : cnt[4] + 8'd1) : cnt[4];
    nx[5] = t_day    ? (d_wrap  ? 8'h01 : bcd_inc(cnt[5])) : cnt[5];
    nx[6] = t_mon    ? (mo_wrap ? 8'h01 : bcd_inc(cnt[6])) : cnt[6];
    nx[7] = t_yr     ? ((cnt[7] == 8'h99) ? 8'h00 : bcd_inc(cnt[7])) : cnt[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
    end else if (load) begin
      pre <= '0;
    end else if (osc_en && !osc_stop) begin
      pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_bit    <= 1'b0;
      r_bit    <= 1'b0;
      century  <= '0;
      osc_stop <= 1'b0;
      ft_en    <= 1'b0;
      for (int i = 1; i < 8; i++) begin
        usr[i] <= reset_val(i);
        cnt[i] <= reset_val(i);
      end
    end else begin
      for (int i = 1; i < 8; i++) begin
        cnt[i] <= load ? usr[i] : nx[i];
        if (!w_bit && !r_bit) usr[i] <= cnt[i];
        else if (w_bit && wr && addr == 3'(i)) usr[i] <= dq_in & field_mask(i);
      end
      if (ctrl_wr) begin
        w_bit <= dq_in[7];
        r_bit <= dq_in[6];
        if (w_bit && !dq_in[7] && !dq_in[6]) century <= dq_in[5:0];
      end
      if (wr && addr == 3'd1) osc_stop <= dq_in[7];
      if (wr && addr == 3'd4) ft_en    <= dq_in[6];
    end
  end

  always_comb begin
    case (addr)
      3'd0:    dq_out = {w_bit, r_bit, century};
      3'd1:    dq_out = {osc_stop, usr[1][6:1], sec_lsb};
      3'd2:    dq_out = usr[2];
      3'd3:    dq_out = usr[3];
      3'd4:    dq_out = {1'b0, ft_en, usr[4][5:0]};
      3'd5:    dq_out = usr[5];
      3'd6:    dq_out = usr[6];
      default: dq_out = usr[7];
    endcase
  end

  p_pf_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> ($stable(w_bit) && $stable(r_bit) && $stable(century)));
  p_load_counter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt[1] == $past(usr[1]) && cnt[7] == $past(usr[7])));
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (r_bit && !w_bit) |=> ($stable(usr[1]) && $stable(usr[2])));
  p_century_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (dq_in[7] || dq_in[6])) |=> $stable(century));
  p_sec_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[1] <= 8'h59 && cnt[1][3:0] <= 4'd9));
  p_osc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop && !load) |=> $stable(cnt[1]));
endmodule

// File: tb/bcd_rtc_regs_test.sv
module bcd_rtc_regs_test;
  localparam int HZ = 4096;
  logic clk = 1'b0, rst_n = 1'b0, osc_en = 1'b1, pwr_fail = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] dq_in = '0, dq_out;
  logic dq_oe;
  int errors = 0, checks = 0;
  bit done = 0;

  bcd_rtc_regs #(.TICK_HZ(HZ), .TEST_HZ(512)) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .pwr_fail(pwr_fail),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dq_in = d; ce_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk);
    ce_n = 1; we_n = 1;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    #2 d = dq_out;
    @(negedge clk);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dw, dt, mo, y);
    bus_write(0, 8'h80);
    bus_write(1, s);  bus_write(2, mi); bus_write(3, h);
    bus_write(4, dw); bus_write(5, dt); bus_write(6, mo); bus_write(7, y);
    bus_write(0, 8'h20);
  endtask

  task automatic t_reset;
    expect_reg("R12 control", 0, 8'h00);
    expect_reg("R12 seconds", 1, 8'h00);
    expect_reg("R12 day", 4, 8'h01);
    expect_reg("R12 date", 5, 8'h01);
    expect_reg("R12 month", 6, 8'h01);
    expect_reg("R12 year", 7, 8'h00);
  endtask

  task automatic t_rollover;
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    expect_reg("R3 seconds loaded", 1, 8'h58);
    expect_reg("R4 century on W clear", 0, 8'h20);
    wait_cyc(HZ - 8);
    expect_reg("R4 no advance before a full second", 1, 8'h58);
    wait_cyc(HZ + 4);
    expect_reg("R7 seconds wrap", 1, 8'h00);
    expect_reg("R7 minutes wrap", 2, 8'h00);
    expect_reg("R7 hours wrap", 3, 8'h00);
    expect_reg("R7 day 7 to 1", 4, 8'h01);
    expect_reg("R8 Feb 28 non-leap", 5, 8'h01);
    expect_reg("R8 month to March", 6, 8'h03);
  endtask

  task automatic t_leap_and_short;
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    wait_cyc(HZ + 4);
    expect_reg("R8 leap Feb 29", 5, 8'h29);
    expect_reg("R7 day 3 to 4", 4, 8'h04);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h00);
    wait_cyc(HZ + 4);
    expect_reg("R8 year 00 Feb 29 ends", 5, 8'h01);
    expect_reg("R8 month after leap Feb", 6, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h24);
    wait_cyc(HZ + 4);
    expect_reg("R8 April 30 date", 5, 8'h01);
    expect_reg("R8 April 30 month", 6, 8'h05);
  endtask

  task automatic t_year;
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    wait_cyc(HZ + 4);
    expect_reg("R9 year 99 to 00", 7, 8'h00);
    expect_reg("R8 December wraps month", 6, 8'h01);
    expect_reg("R9 century unchanged", 0, 8'h20);
  endtask

  task automatic t_read_hold;
    set_time(8'h10, 8'h00, 8'h10, 8'h02, 8'h15, 8'h06, 8'h24);
    bus_write(0, 8'h40);
    expect_reg("R6 century kept when R set", 0, 8'h60);
    wait_cyc(HZ + 4);
    expect_reg("R5 frozen seconds", 1, 8'h10);
    bus_write(0, 8'h00);
    expect_reg("R6 century kept on R clear", 0, 8'h20);
    expect_reg("R5 elapsed time after release", 1, 8'h11);
  endtask

  task automatic t_write_hold;
    bus_write(0, 8'h85);
    expect_reg("R6 century kept when W set", 0, 8'hA0);
    expect_reg("R3 W bit reads back", 0, 8'hA0);
    bus_write(1, 8'h33);
    expect_reg("R3 time write while W", 1, 8'h33);
    bus_write(0, 8'h19);
    expect_reg("R6 century written on W clear", 0, 8'h19);
    bus_write(1, 8'h44);
    expect_reg("R3 time write ignored without W", 1, 8'h33);
  endtask

  task automatic t_osc;
    bus_write(1, 8'h80);
    expect_reg("R10 osc bit reads back", 1, 8'hB3);
    wait_cyc(HZ + 100);
    expect_reg("R10 no count while stopped", 1, 8'hB3);
    bus_write(1, 8'h00);
    expect_reg("R10 restart", 1, 8'h33);
  endtask

  task automatic t_freq_test;
    logic [7:0] v;
    int toggles;
    logic prev;
    bus_write(4, 8'h40);
    bus_read(4, v);
    check("R11 test bit reads back", v & 8'h40, 8'h40);
    check("R11 day field untouched", v & 8'h07, 8'h02);
    @(negedge clk);
    addr = 1; ce_n = 0; oe_n = 0; we_n = 1;
    #2 prev = dq_out[0];
    toggles = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      #2 if (dq_out[0] != prev) toggles++;
      prev = dq_out[0];
    end
    check("R11 toggle count running", 8'(toggles >= 3 && toggles <= 4), 8'd1);
    ce_n = 1; oe_n = 1;
    bus_write(1, 8'h80);
    @(negedge clk);
    addr = 1; ce_n = 0; oe_n = 0; we_n = 1;
    toggles = 0;
    #2 prev = dq_out[0];
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      #2 if (dq_out[0] != prev) toggles++;
      prev = dq_out[0];
    end
    check("R11 no toggle when stopped", 8'(toggles), 8'd0);
    check("R11 stored LSB shown", dq_out, 8'hB3);
    ce_n = 1; oe_n = 1;
    bus_write(1, 8'h00);
    bus_write(4, 8'h00);
  endtask

  task automatic t_bus;
    @(negedge clk);
    addr = 0; ce_n = 1; oe_n = 0; we_n = 1;
    #2 check("R1 deselected", 8'(dq_oe), 8'd0);
    ce_n = 0; oe_n = 1;
    #2 check("R1 output disabled", 8'(dq_oe), 8'd0);
    oe_n = 0;
    #2 check("R1 read drives", 8'(dq_oe), 8'd1);
    pwr_fail = 1;
    #2 check("R2 power fail releases bus", 8'(dq_oe), 8'd0);
    dq_in = 8'h80; we_n = 0;
    #2 check("R1 write mode undriven", 8'(dq_oe), 8'd0);
    @(negedge clk);
    ce_n = 1; we_n = 1; oe_n = 1; pwr_fail = 0;
    expect_reg("R2 write ignored on power fail", 0, 8'h19);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_rollover;
    t_leap_and_short;
    t_year;
    t_read_hold;
    t_write_hold;
    t_osc;
    t_freq_test;
    t_bus;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule